// File: doc/BRIEF.md
# Shared Last-Level Cache Tag Controller with Selectable IO Handling

This block is the tag and replacement engine of a set-associative shared last-level cache. The cache sits on a snooped system bus in front of slow DRAM. Each bus transaction, whether it comes from a processor or from an IO agent, starts a tag lookup and a DRAM access in the same cycle. On the following cycle the block reports a hit or a miss. A hit also pulses an abort toward the DRAM controller, so the parallel access is cancelled and the cached copy is used. On a miss the DRAM access runs to completion, and the tag is installed at the end of the lookup cycle, ready for the block to be filled.

The block keeps a tag, a valid bit and a true-LRU age for every frame. Processor transactions allocate on a miss and refresh the LRU order on a hit. Processor write-flushes remove the block. IO agents reading or writing plainly always invalidate the block. IO write-flushes follow a mode input sampled with each transaction: invalidate, update only if present, or allocate like a processor reference. The payload storage and the DRAM timing lie outside this block.

Top module: `l3c_top`

## Requirements
- R1: `dramStart` is high in exactly the cycles where `busValid` is high, in the same cycle as the lookup.
- R2: One cycle after each transaction, exactly one of `hitPulse` or `missPulse` is high for one cycle. Hit means a valid frame in the indexed set holds the same tag. The address splits into block offset (low log2(BLOCK_BYTES) bits, ignored), set index (next log2(SETS) bits) and tag (the remaining upper bits). Both pulses are low after an idle cycle.
- R3: `dramAbort` pulses together with `hitPulse` and never on a miss.
- R4: A processor transaction (`busIsIo`=0) of any `busType` other than 4 (0 read, 1 read-exclusive, 2 write-invalidate, 3 upgrade) refreshes the LRU order on a hit and allocates the block on a miss.
- R5: A processor write-flush (`busType`=4, `busIsIo`=0) invalidates the block.
- R6: An IO transaction with `busType` other than 4 (IO read, plain IO write) invalidates the block, whatever `ioMode` holds.
- R7: An IO write-flush (`busIsIo`=1, `busType`=4) with `ioMode` 00 invalidates the block. The unused code 11 behaves the same way.
- R8: An IO write-flush with `ioMode` 01 refreshes the LRU order on a hit and leaves the cache unchanged on a miss.
- R9: An IO write-flush with `ioMode` 10 is treated exactly like a processor read: refresh on a hit, allocate on a miss.
- R10: An allocation takes the lowest-numbered invalid way of the set when one exists. Otherwise it takes the least recently used way.
- R11: After reset every frame is invalid, so any first access misses, and all outputs are low while reset is held.
- R12: Sets are independent. A transaction changes only the set its address indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | A bus transaction is present this cycle |
| busIsIo | input | 1 | 1 when the transaction comes from an IO agent |
| busType | input | 3 | 0 read, 1 read-exclusive, 2 write-invalidate, 3 upgrade, 4 write-flush |
| busAddr | input | ADDR_W | Physical byte address |
| ioMode | input | 2 | IO write-flush handling: 00 invalidate, 01 update, 10 allocate |
| dramStart | output | 1 | Starts the DRAM access alongside the lookup |
| dramAbort | output | 1 | One-cycle pulse that cancels the DRAM access on a hit |
| hitPulse | output | 1 | One-cycle hit indication |
| missPulse | output | 1 | One-cycle miss indication |

## Verification
The assertions take for granted that `busType`, `busIsIo` and `ioMode` are stable and meaningful whenever `busValid` is high. They also assume that reset is applied before the first transaction, so the tag array never holds two valid copies of one tag in a set. The stimulus drives every field on the falling edge, changes it only there, and reaches the tag array only through bus transactions after reset. It therefore never creates a duplicate tag except through the design's own allocation path, which is what the single-match check guards.

// File: rtl/l3c_pkg.sv
package l3c_pkg;

  typedef enum logic [2:0] {
    TX_READ  = 3'd0,
    TX_READX = 3'd1,
    TX_WRINV = 3'd2,
    TX_UPGR  = 3'd3,
    TX_WRFL  = 3'd4
  } txKind_e;

  localparam logic [1:0] MODE_INVAL  = 2'b00;
  localparam logic [1:0] MODE_UPDATE = 2'b01;
  localparam logic [1:0] MODE_ALLOC  = 2'b10;

  // Strobes from the decoder to the tag datapath.
  typedef struct packed {
    logic lookup;
    logic touchOnHit;
    logic allocOnMiss;
    logic invalOnHit;
  } tagCmd_t;

endpackage

// File: rtl/l3c_ctrl.sv
module l3c_ctrl
  import l3c_pkg::*;
(
  input  logic       busValid,
  input  logic       busIsIo,
  input  logic [2:0] busType,
  input  logic [1:0] ioMode,
  output tagCmd_t    cmd
);

  logic isFlush;
  assign isFlush = (busType == TX_WRFL);

  always_comb begin
    cmd = '0;
    cmd.lookup = busValid;
    if (busValid) begin
      if (!busIsIo) begin
        if (isFlush) cmd.invalOnHit = 1'b1;
        else begin
          cmd.touchOnHit  = 1'b1;
          cmd.allocOnMiss = 1'b1;
        end
      end else if (!isFlush) begin
        cmd.invalOnHit = 1'b1;
      end else begin
        unique case (ioMode)
          MODE_UPDATE: cmd.touchOnHit = 1'b1;
          MODE_ALLOC: begin
            cmd.touchOnHit  = 1'b1;
            cmd.allocOnMiss = 1'b1;
          end
          default: cmd.invalOnHit = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    // R5 R7: an invalidating command never also refreshes or allocates
    a_r5_inval_exclusive: assert (!(cmd.invalOnHit && (cmd.touchOnHit || cmd.allocOnMiss)));
    // R6: IO accesses other than write-flush always invalidate
    a_r6_io_plain_inval: assert (!(busValid && busIsIo && !isFlush) || cmd.invalOnHit);
  end

endmodule

// File: rtl/l3c_tags.sv
module l3c_tags
  import l3c_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 128,
  parameter int SETS        = 16,
  parameter int WAYS        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagCmd_t           cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              hitQ,
  output logic              missQ,
  output logic              abortQ
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [WAY_W-1:0] ageQ   [SETS][WAYS];
  logic [WAYS-1:0]  validQ [SETS];

  logic [IDX_W-1:0] setIdx;
  logic [TAG_W-1:0] tagIn;
  assign setIdx = addr[OFF_W +: IDX_W];
  assign tagIn  = addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] hitVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[setIdx][w] && (tagQ[setIdx][w] == tagIn);
  end

  logic anyHit;
  logic [WAY_W-1:0] hitWay, victimWay, touchWay;
  logic foundFree;
  assign anyHit = |hitVec;

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    victimWay = '0;
    foundFree = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!validQ[setIdx][w] && !foundFree) begin
        victimWay = WAY_W'(w);
        foundFree = 1'b1;
      end
    if (!foundFree)
      for (int w = 0; w < WAYS; w++)
        if (ageQ[setIdx][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
  end

  logic doInval, doTouch, doAlloc;
  assign doInval = cmd.lookup && anyHit && cmd.invalOnHit;
  assign doAlloc = cmd.lookup && !anyHit && cmd.allocOnMiss;
  assign doTouch = doAlloc || (cmd.lookup && anyHit && cmd.touchOnHit && !cmd.invalOnHit);
  assign touchWay = anyHit ? hitWay : victimWay;

  logic [WAY_W-1:0] newAge [WAYS];
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touchWay) newAge[w] = '0;
      else if (ageQ[setIdx][w] < ageQ[setIdx][touchWay]) newAge[w] = ageQ[setIdx][w] + 1'b1;
      else newAge[w] = ageQ[setIdx][w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tagQ[s][w] <= '0;
          ageQ[s][w] <= WAY_W'(w);
        end
      end
      hitQ   <= 1'b0;
      missQ  <= 1'b0;
      abortQ <= 1'b0;
    end else begin
      hitQ   <= cmd.lookup && anyHit;
      missQ  <= cmd.lookup && !anyHit;
      abortQ <= cmd.lookup && anyHit;
      if (doInval) validQ[setIdx][hitWay] <= 1'b0;
      if (doAlloc) begin
        validQ[setIdx][victimWay] <= 1'b1;
        tagQ[setIdx][victimWay]   <= tagIn;
      end
      if (doTouch)
        for (int w = 0; w < WAYS; w++) ageQ[setIdx][w] <= newAge[w];
    end
  end

  // Checker bookkeeping: remember the last installed frame.
  logic [IDX_W-1:0] lastSetQ;
  logic [WAY_W-1:0] lastWayQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSetQ <= '0;
      lastWayQ <= '0;
    end else if (doAlloc) begin
      lastSetQ <= setIdx;
      lastWayQ <= victimWay;
    end
  end

  // R2: a tag is held at most once per set
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rstN)
    cmd.lookup |-> $onehot0(hitVec));
  // R2: hit and miss never together
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(hitQ && missQ));
  // R9 R10: an allocation leaves its frame valid
  a_r10_alloc_installs: assert property (@(posedge clk) disable iff (!rstN)
    doAlloc |=> validQ[lastSetQ][lastWayQ]);

endmodule

// File: rtl/l3c_top.sv
module l3c_top
  import l3c_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 128,
  parameter int SETS        = 16,
  parameter int WAYS        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busIsIo,
  input  logic [2:0]        busType,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        ioMode,
  output logic              dramStart,
  output logic              dramAbort,
  output logic              hitPulse,
  output logic              missPulse
);

  tagCmd_t cmd;

  l3c_ctrl u_ctrl (
    .busValid (busValid),
    .busIsIo  (busIsIo),
    .busType  (busType),
    .ioMode   (ioMode),
    .cmd      (cmd)
  );

  l3c_tags #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .SETS        (SETS),
    .WAYS        (WAYS)
  ) u_tags (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .addr   (busAddr),
    .hitQ   (hitPulse),
    .missQ  (missPulse),
    .abortQ (dramAbort)
  );

  assign dramStart = busValid;

  // R3: abort only with a hit
  a_r3_abort_with_hit: assert property (@(posedge clk) disable iff (!rstN)
    dramAbort |-> hitPulse);
  // R2: a response only follows a transaction
  a_r2_pulse_needs_txn: assert property (@(posedge clk) disable iff (!rstN)
    (hitPulse || missPulse) |-> $past(busValid));

endmodule

// File: tb/l3c_top_bench.sv
`timescale 1ns/1ps
module l3c_top_bench;

  localparam int ADDR_W = 32;
  localparam int BLOCK_BYTES = 128;
  localparam int SETS = 16;
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int NVEC = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busIsIo = 1'b0;
  logic [2:0] busType = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0] ioMode = '0;
  logic dramStart, dramAbort, hitPulse, missPulse;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  l3c_top #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .SETS(SETS), .WAYS(4)) u_l3c_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busIsIo(busIsIo), .busType(busType),
    .busAddr(busAddr), .ioMode(ioMode), .dramStart(dramStart), .dramAbort(dramAbort),
    .hitPulse(hitPulse), .missPulse(missPulse));

  // {isIo, type[2:0], mode[1:0], set[3:0], tag[7:0], expectHit}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 2'd0, 4'd0, 8'd0, 1'b0}, // R11 empty cache, tag 0 misses
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd1, 1'b0}, // R4 fill way0
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd2, 1'b0}, // R10 way1
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd3, 1'b0}, // R10 way2
    {1'b0, 3'd1, 2'd0, 4'd3, 8'd4, 1'b0}, // R4 read-excl fills way3
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd1, 1'b1}, // R4 hit refreshes T1
    {1'b0, 3'd2, 2'd0, 4'd3, 8'd5, 1'b0}, // R10 evicts LRU T2
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd2, 1'b0}, // R10 T2 gone, evicts T3
    {1'b0, 3'd4, 2'd0, 4'd3, 8'd5, 1'b1}, // R5 proc flush invalidates T5
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd5, 1'b0}, // R5 miss, refills free way
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd4, 1'b1}, // R10 LRU T4 kept
    {1'b1, 3'd0, 2'd1, 4'd3, 8'd4, 1'b1}, // R6 IO read invalidates
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd4, 1'b0}, // R6 T4 gone
    {1'b1, 3'd4, 2'd1, 4'd3, 8'd6, 1'b0}, // R8 update miss, no alloc
    {1'b1, 3'd4, 2'd1, 4'd3, 8'd1, 1'b1}, // R8 update hit refreshes T1
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd6, 1'b0}, // R8 T6 absent, evicts T2
    {1'b1, 3'd4, 2'd2, 4'd3, 8'd7, 1'b0}, // R9 allocate evicts T5
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd7, 1'b1}, // R9 T7 present
    {1'b1, 3'd4, 2'd0, 4'd3, 8'd7, 1'b1}, // R7 invalidate mode
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd7, 1'b0}, // R7 T7 gone
    {1'b1, 3'd2, 2'd1, 4'd3, 8'd1, 1'b1}, // R6 plain IO write under update mode
    {1'b0, 3'd3, 2'd0, 4'd3, 8'd1, 1'b0}, // R6 R4 upgrade misses, allocates
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd4, 1'b1}, // R10 free way taken before LRU T4
    {1'b0, 3'd0, 2'd0, 4'd5, 8'd1, 1'b0}, // R12 other set misses
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd1, 1'b1}, // R12 set 3 untouched
    {1'b1, 3'd4, 2'd3, 4'd3, 8'd1, 1'b1}, // R7 code 11 invalidates
    {1'b0, 3'd0, 2'd0, 4'd3, 8'd1, 1'b0}  // R7 T1 gone
  };

  function automatic logic [ADDR_W-1:0] mkAddr(input logic [7:0] tag, input logic [3:0] set);
    logic [OFF_W-1:0] off;
    off = OFF_W'((tag * 37 + 5) % BLOCK_BYTES);
    return (ADDR_W'(tag) << (OFF_W + IDX_W)) | (ADDR_W'(set) << OFF_W) | ADDR_W'(off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic io, input logic [2:0] ty, input logic [1:0] md,
                      input logic [3:0] set, input logic [7:0] tag, input logic expHit,
                      input string req);
    busValid = 1'b1; busIsIo = io; busType = ty; ioMode = md; busAddr = mkAddr(tag, set);
    #1 chk("R1 dramStart", 32'(dramStart), 32'd1);
    @(negedge clk);
    chk({req, " hit"}, 32'(hitPulse), 32'(expHit));
    chk({req, " miss"}, 32'(missPulse), 32'(!expHit));
    chk({"R3 ", req, " abort"}, 32'(dramAbort), 32'(expHit));
    busValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset hit", 32'(hitPulse), 32'd0);
    chk("R11 reset miss", 32'(missPulse), 32'd0);
    chk("R11 reset abort", 32'(dramAbort), 32'd0);
    chk("R1 idle dramStart", 32'(dramStart), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      v = VEC[i];
      send(v[18], v[17:15], v[14:13], v[12:9], v[8:1], v[0], $sformatf("R2 vec%0d", i));
    end
    #1 chk("R1 idle dramStart", 32'(dramStart), 32'd0);
    @(negedge clk);
    chk("R2 idle no hit", 32'(hitPulse), 32'd0);
    chk("R2 idle no miss", 32'(missPulse), 32'd0);
    chk("R3 idle no abort", 32'(dramAbort), 32'd0);
    // R11: reset mid-run clears every frame
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    send(1'b0, 3'd0, 2'd0, 4'd3, 8'd4, 1'b0, "R11 after reset");
    send(1'b0, 3'd0, 2'd0, 4'd3, 8'd4, 1'b1, "R4 back-to-back refill");
    // R9: allocate mode fills an empty set, later read hits
    send(1'b1, 3'd4, 2'd2, 4'd9, 8'd33, 1'b0, "R9 alloc empty set");
    send(1'b0, 3'd0, 2'd0, 4'd9, 8'd33, 1'b1, "R9 alloc visible");
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule